// File: doc/BRIEF.md
# Fenced Store Buffer

This block sits between a processor's request port and a slow memory port. A store is taken into a small queue in a single cycle, so the core can keep issuing requests without waiting for the memory write. The queue writes its stores to memory in the order they arrived, one at a time. The next write starts only after the previous one has been acknowledged.

A load to an address that no queued store targets goes straight to memory, ahead of the older stores still waiting. A load whose address matches a queued or in-flight store is not served from the queue. The block holds that load until every matching store has been acknowledged by memory, so the value it returns comes from memory.

Three fence requests let software restore ordering where it matters:
- A full fence orders both loads and stores.
- A load fence orders loads only.
- A store fence orders stores only.

A fence is accepted and acknowledged as soon as its condition holds. No later request passes the fence before that.

Request encodings on `req_op`: 0 is a load, 1 is a store, 2 is a fence. Fence kinds on `req_fkind`: 0 is full, 1 is load-only, 2 is store-only.

Top module: `sbuf_fence_top`

## Requirements
- R1: When the queue is not full, a store request (`req_op`=1) is accepted in the same cycle it is presented (`req_ready` high), without waiting for memory.
- R2: Queued stores reach memory in the order they were accepted. A new memory write is never issued while an earlier write is unacknowledged.
- R3: With all DEPTH entries occupied (the entry being written counts), a store request sees `req_ready` low until an entry is freed by a write acknowledge.
- R4: A load (`req_op`=0) whose address matches no queued store is issued to memory and answered while older stores to other addresses are still uncommitted.
- R5: A load whose address matches any queued or in-flight store is held (`req_ready` low) until all such stores are acknowledged. The data it then returns is the value of the youngest earlier store to that address.
- R6: A store to an address that already has pending stores is accepted without stall and queued behind them.
- R7: When an unblocked load and the head of the queue both want the memory port in the same cycle, the load is issued first.
- R8: A full fence (`req_fkind`=0) is acknowledged (`fence_done`) only when the queue is empty and no load is outstanding.
- R9: A load fence (`req_fkind`=1) is acknowledged once no load is outstanding, even while stores remain queued.
- R10: A store fence (`req_fkind`=2) is acknowledged only once every earlier store has been acknowledged by memory.
- R11: After reset no memory request, load response or fence acknowledge is driven until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 fence |
| req_fkind | input | 2 | Fence kind: 0 full, 1 loads, 2 stores |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_rdata | output | DW | Load data |
| fence_done | output | 1 | Fence acknowledge, high in the accepting cycle |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory completion pulse (read data or write acknowledge) |
| mem_rsp_rdata | input | DW | Memory read data |

## Verification
Corrupted queue pointers or valid bits show up in two places at the ports. Loads return stale values, or the sequence of committed writes differs from the order stores were accepted. The write sequence is compared once the final fence has drained everything. A hazard check that misses an entry shows up as wrong load data on the same response, roughly one memory write latency after the load is issued. A wrong fence condition appears in the acknowledge cycle itself, because the number of committed writes sampled there falls short of the number of stores accepted.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam logic [1:0] OP_LOAD   = 2'd0;
  localparam logic [1:0] OP_STORE  = 2'd1;
  localparam logic [1:0] OP_FENCE  = 2'd2;

  typedef enum logic [1:0] {
    FK_ALL    = 2'd0,
    FK_LOADS  = 2'd1,
    FK_STORES = 2'd2
  } fence_kind_e;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] probe_addr,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          head_vld,
  output logic          full,
  output logic          empty,
  output logic          hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [DEPTH-1:0] hit_vec;

  // address compare against every live entry, in-flight head included
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (addr_q[i] == probe_addr);
  end

  always_comb begin
    vld_d    = vld_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (pop) begin
      vld_d[rd_ptr_q] = 1'b0;
      rd_ptr_d        = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push) begin
      vld_d[wr_ptr_q] = 1'b1;
      wr_ptr_d        = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      vld_q    <= vld_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign head_vld  = vld_q[rd_ptr_q];
  assign full      = &vld_q;
  assign empty     = ~|vld_q;
  assign hit       = |hit_vec;
endmodule

// File: rtl/sbuf_track.sv
module sbuf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_go,
  input  logic dr_go,
  input  logic mem_rsp_valid,
  output logic wr_busy,
  output logic ld_pend,
  output logic wr_done,
  output logic rd_done
);
  logic wr_busy_d, ld_pend_d;

  assign wr_done = mem_rsp_valid && wr_busy;
  assign rd_done = mem_rsp_valid && ld_pend;

  always_comb begin
    wr_busy_d = wr_busy;
    ld_pend_d = ld_pend;
    if (wr_done) wr_busy_d = 1'b0;
    if (rd_done) ld_pend_d = 1'b0;
    if (dr_go)   wr_busy_d = 1'b1;
    if (ld_go)   ld_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy <= 1'b0;
      ld_pend <= 1'b0;
    end else begin
      wr_busy <= wr_busy_d;
      ld_pend <= ld_pend_d;
    end
  end
endmodule

// File: rtl/sbuf_memarb.sv
module sbuf_memarb #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          ld_want,
  input  logic [AW-1:0] ld_addr,
  input  logic          dr_want,
  input  logic [AW-1:0] dr_addr,
  input  logic [DW-1:0] dr_data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ld_go,
  output logic          dr_go
);
  // a waiting load takes the port before the queue head
  assign mem_valid = ld_want || dr_want;
  assign mem_we    = !ld_want && dr_want;
  assign mem_addr  = ld_want ? ld_addr : dr_addr;
  assign mem_wdata = dr_data;
  assign ld_go     = ld_want && mem_ready;
  assign dr_go     = !ld_want && dr_want && mem_ready;
endmodule

// File: rtl/sbuf_fence_top.sv
module sbuf_fence_top
  import sbuf_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_fkind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          fence_done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  logic rs_meta, rs_n;
  logic is_ld, is_st, is_fc, fc_ok;
  logic buf_full, buf_empty, ld_hit, head_vld;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic wr_busy, ld_pend, wr_done, rd_done;
  logic ld_want, dr_want, ld_go, dr_go, push;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_n, rs_meta} <= 2'b00;
    else        {rs_n, rs_meta} <= {rs_meta, 1'b1};
  end

  assign is_ld = req_valid && (req_op == OP_LOAD);
  assign is_st = req_valid && (req_op == OP_STORE);
  assign is_fc = req_valid && (req_op == OP_FENCE);

  always_comb begin
    case (fence_kind_e'(req_fkind))
      FK_LOADS:  fc_ok = !ld_pend;
      FK_STORES: fc_ok = buf_empty;
      default:   fc_ok = buf_empty && !ld_pend;
    endcase
  end

  assign ld_want = is_ld && !ld_hit && !ld_pend;
  assign dr_want = head_vld && !wr_busy;
  assign push    = is_st && !buf_full;

  sbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fifo_i (
    .clk(clk), .rst_n(rs_n), .push(push), .push_addr(req_addr),
    .push_data(req_wdata), .pop(wr_done), .probe_addr(req_addr),
    .head_addr(head_addr), .head_data(head_data), .head_vld(head_vld),
    .full(buf_full), .empty(buf_empty), .hit(ld_hit)
  );

  sbuf_track track_i (
    .clk(clk), .rst_n(rs_n), .ld_go(ld_go), .dr_go(dr_go),
    .mem_rsp_valid(mem_rsp_valid), .wr_busy(wr_busy), .ld_pend(ld_pend),
    .wr_done(wr_done), .rd_done(rd_done)
  );

  sbuf_memarb #(.AW(AW), .DW(DW)) arb_i (
    .ld_want(ld_want), .ld_addr(req_addr), .dr_want(dr_want),
    .dr_addr(head_addr), .dr_data(head_data), .mem_ready(mem_req_ready),
    .mem_valid(mem_req_valid), .mem_we(mem_req_we), .mem_addr(mem_req_addr),
    .mem_wdata(mem_req_wdata), .ld_go(ld_go), .dr_go(dr_go)
  );

  assign req_ready  = ld_go || push || (is_fc && fc_ok);
  assign fence_done = is_fc && fc_ok;
  assign rsp_valid  = rd_done;
  assign rsp_rdata  = mem_rsp_rdata;
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic [1:0] req_fkind,
  input logic       mem_req_valid,
  input logic       mem_req_ready,
  input logic       mem_req_we,
  input logic       fence_done,
  input logic       full,
  input logic       empty,
  input logic       hit,
  input logic       wr_busy,
  input logic       ld_pend,
  input logic       dr_want
);
  assert_store_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 && !full) |-> req_ready);
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_we) |-> !wr_busy);
  assert_busy_has_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !empty);
  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 && full) |-> !req_ready);
  assert_hit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && hit) |-> !req_ready);
  assert_load_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && !hit && !ld_pend && dr_want)
      |-> (mem_req_valid && !mem_req_we));
  assert_full_fence_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && req_fkind == 2'd0) |-> (empty && !ld_pend));
  assert_load_fence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && req_fkind == 2'd1) |-> !ld_pend);
  assert_store_fence_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && req_fkind == 2'd2) |-> (empty && !wr_busy));
endmodule

bind sbuf_fence_top sbuf_chk chk_i (
  .clk(clk), .rst_n(rs_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_fkind(req_fkind), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .fence_done(fence_done), .full(buf_full), .empty(buf_empty), .hit(ld_hit),
  .wr_busy(wr_busy), .ld_pend(ld_pend), .dr_want(dr_want)
);

// File: tb/sbuf_fence_top_tb.sv
`timescale 1ns/1ps
module sbuf_fence_top_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int WR_LAT = 100;
  localparam int RD_LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, rsp_valid, fence_done;
  logic [1:0] req_op, req_fkind;
  logic [AW-1:0] req_addr, mem_req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_req_wdata, mem_rsp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;

  always #2.5 clk = ~clk;

  sbuf_fence_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_fkind(req_fkind), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fence_done(fence_done), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // slow memory model: one operation at a time, fixed latency
  logic [DW-1:0] mem [16];
  logic [DW-1:0] shadow [16];
  int cnt, commits;
  logic m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [AW-1:0] clog_addr [1024];
  logic [DW-1:0] clog_data [1024];
  assign mem_req_ready = (cnt == 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        cnt <= mem_req_we ? WR_LAT : RD_LAT;
        m_we <= mem_req_we; m_addr <= mem_req_addr; m_data <= mem_req_wdata;
      end else if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          mem_rsp_valid <= 1'b1;
          if (m_we) begin
            mem[m_addr] <= m_data;
            clog_addr[commits] <= m_addr;
            clog_data[commits] <= m_data;
            commits <= commits + 1;
          end else mem_rsp_rdata <= mem[m_addr];
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0, issued = 0;
  int last_waits, last_commits, last_lat;
  logic last_done;
  logic [DW-1:0] last_rdata;
  logic [AW-1:0] exp_addr [1024];
  logic [DW-1:0] exp_data [1024];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] kind,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_fkind = kind; req_addr = a; req_wdata = d;
    #1; last_waits = 0;
    while (!req_ready) begin @(negedge clk); #1; last_waits++; end
    last_done = fence_done;
    last_commits = commits;
    if (op == 2'd1) begin
      exp_addr[issued] = a; exp_data[issued] = d; issued++; shadow[a] = d;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    issue(2'd0, 2'd0, a, '0);
    last_lat = 0;
    do begin @(negedge clk); last_lat++; end while (!rsp_valid);
    last_rdata = rsp_rdata;
    last_commits = commits;
  endtask

  int c0;
  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
    commits = 0;
    req_valid = 1'b0; req_op = 2'd1; req_fkind = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: idle outputs after reset
    chk(!mem_req_valid, "R11 mem_req_valid", int'(mem_req_valid), 0);
    chk(!rsp_valid, "R11 rsp_valid", int'(rsp_valid), 0);
    chk(!fence_done, "R11 fence_done", int'(fence_done), 0);

    issue(2'd1, 0, 4'd0, 16'h1111);
    chk(last_waits == 0, "R1 single-cycle store", last_waits, 0);
    issue(2'd1, 0, 4'd0, 16'h2222);
    chk(last_waits == 0, "R6 same-address store", last_waits, 0);
    issue(2'd1, 0, 4'd0, 16'h3333);
    chk(last_waits == 0, "R6 same-address store", last_waits, 0);
    issue(2'd1, 0, 4'd1, 16'h4444);
    chk(last_waits == 0, "R1 fourth store", last_waits, 0);
    issue(2'd1, 0, 4'd2, 16'h5555);
    chk(last_waits > 0, "R3 full queue stalls", last_waits, 1);
    issue(2'd2, 2'd2, 4'd0, '0);
    chk(last_done && last_commits == issued, "R10 store fence drained", last_commits, issued);

    c0 = commits;
    issue(2'd1, 0, 4'd8, 16'h0808);
    do_load(4'd9);
    chk(last_commits == c0, "R7 load before drain", last_commits, c0);
    chk(last_lat <= RD_LAT + 2, "R7 load latency", last_lat, RD_LAT + 2);

    issue(2'd1, 0, 4'd4, 16'h0404);
    issue(2'd1, 0, 4'd5, 16'h0505);
    issue(2'd1, 0, 4'd6, 16'h0606);
    do_load(4'd7);
    chk(last_commits < issued, "R4 bypass commits", last_commits, issued - 1);
    chk(last_rdata == 16'h0, "R4 bypass data", int'(last_rdata), 0);

    issue(2'd1, 0, 4'd10, 16'hABCD);
    do_load(4'd10);
    chk(last_rdata == 16'hABCD, "R5 matching load data", int'(last_rdata), 16'hABCD);
    chk(last_commits == issued, "R5 store committed first", last_commits, issued);

    issue(2'd1, 0, 4'd11, 16'h0B0B);
    issue(2'd1, 0, 4'd12, 16'h0C0C);
    issue(2'd2, 2'd1, 4'd0, '0);
    chk(last_done && last_waits == 0, "R9 load fence immediate", last_waits, 0);
    chk(last_commits < issued, "R9 stores still queued", last_commits, issued - 1);

    issue(2'd1, 0, 4'd14, 16'h0E0E);
    issue(2'd2, 2'd0, 4'd0, '0);
    chk(last_done && last_commits == issued, "R8 full fence drained", last_commits, issued);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 160; k++) begin
      int sel;
      logic [AW-1:0] a;
      sel = int'($urandom % 10);
      a = AW'($urandom % 8);
      if (sel < 5) begin
        issue(2'd1, 0, a, DW'($urandom));
      end else if (sel < 8) begin
        do_load(a);
        chk(last_rdata == shadow[a], "R5 random load data", int'(last_rdata), int'(shadow[a]));
      end else begin
        logic [1:0] kd;
        kd = 2'($urandom % 3);
        issue(2'd2, kd, 0, '0);
        if (kd == 2'd1) chk(last_done, "R9 random load fence", int'(last_done), 1);
        else chk(last_done && last_commits == issued,
                 (kd == 2'd0) ? "R8 random full fence" : "R10 random store fence",
                 last_commits, issued);
      end
    end

    issue(2'd2, 2'd0, 4'd0, '0);
    chk(commits == issued, "R2 write count", commits, issued);
    begin
      int first_bad = -1;
      for (int i = 0; i < issued; i++)
        if (first_bad < 0 && (clog_addr[i] != exp_addr[i] || clog_data[i] != exp_data[i]))
          first_bad = i;
      chk(first_bad < 0, "R2 write order (first bad index)", first_bad, -1);
    end
    finish_run();
  end
endmodule